// File: doc/BRIEF.md
# ModRM Effective Address Generator

This block turns the addressing byte of a 16-bit segmented instruction, plus up to two displacement bytes, into a memory operand location. From the byte's top two bits (`mode`) and low three bits (`rm`) it adds the right base and index registers to the displacement and picks the segment. It then forms the 20-bit physical address as the segment value shifted left by four plus the offset. When `mode` is 3 the operand is a register, and the block reports that case instead of an address.

The decode stage drives the addressing byte, the two bytes that follow it in the instruction stream, and the current base, index and segment register values, all with `in_valid`. One cycle later the block returns the physical address, the 16-bit offset and the chosen segment. It also returns the register-operand flag with its index and the middle three bits of the byte. Finally it returns how many displacement bytes were used, so the fetch logic can advance the instruction pointer. A segment prefix from the decoder can replace the default segment.

Top module: `ea_gen`

## Requirements
- R1: In memory modes the base term is chosen by `rm`: 0 gives BX+SI, 1 gives BX+DI, 2 gives BP+SI, 3 gives BP+DI, 4 gives SI, 5 gives DI, 6 gives BP and 7 gives BX.
- R2: With `mode`=0 and `rm`=6, no register is used. The offset is the 16-bit word formed by `disp_hi` (upper) and `disp_lo` (lower), and `out_disp_len` is 2.
- R3: With `mode`=1, `disp_lo` is sign-extended to 16 bits and added to the base, and `out_disp_len` is 1.
- R4: With `mode`=2, the little-endian word {`disp_hi`,`disp_lo`} is added to the base, and `out_disp_len` is 2. With `mode`=0 and any `rm` other than 6, there is no displacement and `out_disp_len` is 0.
- R5: All offset additions wrap modulo 65536.
- R6: Segments are encoded as ES=0, CS=1, SS=2, DS=3. With no override, the segment is SS for `rm` 2 or 3 in any memory mode, and for `rm` 6 when `mode` is 1 or 2. Every other memory case uses DS.
- R7: When `ovr_en` is 1, `out_seg` equals `ovr_sel` for a memory operand, whatever the default would have been.
- R8: `out_phys` equals (selected segment value × 16 + `out_offset`) modulo 2^20.
- R9: With `mode`=3, `out_is_reg` is 1 and `out_reg_idx` equals `rm`. In that case `out_offset`, `out_phys` and `out_disp_len` are 0 and `out_seg` has no defined meaning. In memory modes `out_is_reg` is 0. For the consumer, index order 0..7 means AX,CX,DX,BX,SP,BP,SI,DI for words and AL,CL,DL,BL,AH,CH,DH,BH for bytes.
- R10: Results appear one clock after a cycle with `in_valid`=1, marked by `out_valid`=1. Results hold unchanged, with `out_valid`=0, after a cycle with `in_valid`=0. `out_mid` carries bits 5:3 of the byte.
- R11: While `rst` is high at a clock edge, every output becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Inputs are meaningful this cycle |
| modrm | input | 8 | Addressing byte: [7:6] mode, [5:3] middle field, [2:0] rm |
| disp_lo | input | 8 | First byte after the addressing byte |
| disp_hi | input | 8 | Second byte after the addressing byte |
| reg_bx | input | 16 | BX value |
| reg_bp | input | 16 | BP value |
| reg_si | input | 16 | SI value |
| reg_di | input | 16 | DI value |
| seg_es | input | 16 | ES value |
| seg_cs | input | 16 | CS value |
| seg_ss | input | 16 | SS value |
| seg_ds | input | 16 | DS value |
| ovr_en | input | 1 | Segment prefix present |
| ovr_sel | input | 2 | Prefix segment (ES=0, CS=1, SS=2, DS=3) |
| out_valid | output | 1 | Result registered from a valid input |
| out_phys | output | 20 | Physical address |
| out_offset | output | 16 | Effective offset |
| out_seg | output | 2 | Selected segment code |
| out_is_reg | output | 1 | Operand is a register |
| out_reg_idx | output | 3 | Register index when `out_is_reg` |
| out_mid | output | 3 | Middle field of the addressing byte |
| out_disp_len | output | 2 | Displacement bytes used (0, 1 or 2) |

## Verification
The assertions compare registered outputs with the inputs of the previous cycle. They therefore assume that `in_valid` is low throughout reset and that the inputs are stable from the falling edge until the following rising edge. The bench changes inputs only on falling edges and keeps `in_valid` low while `rst` is high, so both assumptions hold. The segment-prefix checks read `ovr_en` only on cycles with a valid input, and the bench gives it a defined value on every such cycle. The register and segment values are chosen so that each base, index and segment case gives a distinct result.

// File: rtl/ea_pkg.sv
package ea_pkg;

    localparam int WORD_W    = 16;
    localparam int PHYS_W    = 20;
    localparam int SEG_SHIFT = 4;

    typedef enum logic [1:0] {
        SEG_ES = 2'd0,
        SEG_CS = 2'd1,
        SEG_SS = 2'd2,
        SEG_DS = 2'd3
    } seg_e;

    typedef enum logic [1:0] {
        MODE_NODISP = 2'd0,
        MODE_DISP8  = 2'd1,
        MODE_DISP16 = 2'd2,
        MODE_REG    = 2'd3
    } amode_e;

    typedef struct packed {
        amode_e     mode;
        logic [2:0] mid;
        logic [2:0] rm;
    } addr_byte_t;

    typedef struct packed {
        logic [PHYS_W-1:0] phys;
        logic [WORD_W-1:0] offset;
        seg_e              seg;
        logic              is_reg;
        logic [2:0]        reg_idx;
        logic [2:0]        mid;
        logic [1:0]        disp_len;
    } ea_result_t;

    // Stack segment is the default whenever BP contributes to the base.
    function automatic seg_e f_default_seg(amode_e mode, logic [2:0] rm);
        if (rm == 3'd2 || rm == 3'd3)
            return SEG_SS;
        if (rm == 3'd6 && mode != MODE_NODISP)
            return SEG_SS;
        return SEG_DS;
    endfunction

    function automatic logic f_is_direct(amode_e mode, logic [2:0] rm);
        return (mode == MODE_NODISP) && (rm == 3'd6);
    endfunction

endpackage

// File: rtl/ea_base_sel.sv
module ea_base_sel
    import ea_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  amode_e       mode,
    input  logic [2:0]   rm,
    input  logic [W-1:0] bx,
    input  logic [W-1:0] bp,
    input  logic [W-1:0] si,
    input  logic [W-1:0] di,
    output logic [W-1:0] base,
    output seg_e         dflt_seg,
    output logic         direct
);
    logic [W-1:0] anchor;
    logic [W-1:0] index;

    always_comb begin
        anchor = '0;
        index  = '0;
        unique case (rm)
            3'd0: begin anchor = bx; index = si; end
            3'd1: begin anchor = bx; index = di; end
            3'd2: begin anchor = bp; index = si; end
            3'd3: begin anchor = bp; index = di; end
            3'd4: index = si;
            3'd5: index = di;
            3'd6: anchor = bp;
            default: anchor = bx;
        endcase
    end

    assign direct   = f_is_direct(mode, rm);
    assign base     = direct ? '0 : anchor + index;
    assign dflt_seg = f_default_seg(mode, rm);

endmodule

// File: rtl/ea_disp_ext.sv
module ea_disp_ext
    import ea_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  amode_e       mode,
    input  logic         direct,
    input  logic [7:0]   lo,
    input  logic [7:0]   hi,
    output logic [W-1:0] disp,
    output logic [1:0]   len
);
    localparam int EXT_W = W - 8;

    logic [W-1:0] word16;
    logic [W-1:0] sext8;

    assign word16 = W'({hi, lo});
    assign sext8  = {{EXT_W{lo[7]}}, lo};

    always_comb begin
        unique case (mode)
            MODE_NODISP: begin
                disp = direct ? word16 : '0;
                len  = direct ? 2'd2 : 2'd0;
            end
            MODE_DISP8: begin
                disp = sext8;
                len  = 2'd1;
            end
            MODE_DISP16: begin
                disp = word16;
                len  = 2'd2;
            end
            default: begin
                disp = '0;
                len  = 2'd0;
            end
        endcase
    end

endmodule

// File: rtl/ea_seg_resolve.sv
module ea_seg_resolve
    import ea_pkg::*;
#(
    parameter int W     = WORD_W,
    parameter int PW    = PHYS_W,
    parameter int SHIFT = SEG_SHIFT
) (
    input  seg_e          dflt_seg,
    input  logic          ovr_en,
    input  logic [1:0]    ovr_sel,
    input  logic [W-1:0]  seg_vals [4],
    input  logic [W-1:0]  offset,
    output seg_e          seg,
    output logic [PW-1:0] phys
);
    localparam int SUM_W = W + SHIFT;

    logic [W-1:0]     seg_val;
    logic [SUM_W-1:0] sum;

    assign seg     = ovr_en ? seg_e'(ovr_sel) : dflt_seg;
    assign seg_val = seg_vals[seg];
    assign sum     = {seg_val, {SHIFT{1'b0}}} + SUM_W'(offset);
    assign phys    = sum[PW-1:0];

endmodule

// File: rtl/ea_gen.sv
module ea_gen
    import ea_pkg::*;
#(
    parameter int W     = WORD_W,
    parameter int PW    = PHYS_W,
    parameter int SHIFT = SEG_SHIFT
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [7:0]    modrm,
    input  logic [7:0]    disp_lo,
    input  logic [7:0]    disp_hi,
    input  logic [W-1:0]  reg_bx,
    input  logic [W-1:0]  reg_bp,
    input  logic [W-1:0]  reg_si,
    input  logic [W-1:0]  reg_di,
    input  logic [W-1:0]  seg_es,
    input  logic [W-1:0]  seg_cs,
    input  logic [W-1:0]  seg_ss,
    input  logic [W-1:0]  seg_ds,
    input  logic          ovr_en,
    input  logic [1:0]    ovr_sel,
    output logic          out_valid,
    output logic [PW-1:0] out_phys,
    output logic [W-1:0]  out_offset,
    output logic [1:0]    out_seg,
    output logic          out_is_reg,
    output logic [2:0]    out_reg_idx,
    output logic [2:0]    out_mid,
    output logic [1:0]    out_disp_len
);
    addr_byte_t  ab;
    logic [W-1:0] base, disp, mem_off;
    logic [W-1:0] seg_vals [4];
    logic [1:0]  dlen;
    logic        direct, reg_op;
    seg_e        dflt_seg, seg_pick;
    logic [PW-1:0] phys_mem;
    ea_result_t  nxt, res;
    logic        valid_q;

    assign ab       = addr_byte_t'(modrm);
    assign reg_op   = (ab.mode == MODE_REG);
    assign seg_vals[SEG_ES] = seg_es;
    assign seg_vals[SEG_CS] = seg_cs;
    assign seg_vals[SEG_SS] = seg_ss;
    assign seg_vals[SEG_DS] = seg_ds;

    ea_base_sel #(.W(W)) u_base (
        .mode(ab.mode), .rm(ab.rm),
        .bx(reg_bx), .bp(reg_bp), .si(reg_si), .di(reg_di),
        .base(base), .dflt_seg(dflt_seg), .direct(direct)
    );

    ea_disp_ext #(.W(W)) u_disp (
        .mode(ab.mode), .direct(direct), .lo(disp_lo), .hi(disp_hi),
        .disp(disp), .len(dlen)
    );

    assign mem_off = reg_op ? '0 : base + disp;

    ea_seg_resolve #(.W(W), .PW(PW), .SHIFT(SHIFT)) u_seg (
        .dflt_seg(dflt_seg), .ovr_en(ovr_en), .ovr_sel(ovr_sel),
        .seg_vals(seg_vals), .offset(mem_off),
        .seg(seg_pick), .phys(phys_mem)
    );

    always_comb begin
        nxt.phys     = reg_op ? '0 : phys_mem;
        nxt.offset   = mem_off;
        nxt.seg      = seg_pick;
        nxt.is_reg   = reg_op;
        nxt.reg_idx  = reg_op ? ab.rm : 3'd0;
        nxt.mid      = ab.mid;
        nxt.disp_len = dlen;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            res     <= '0;
        end else begin
            valid_q <= in_valid;
            if (in_valid)
                res <= nxt;
        end
    end

    assign out_valid    = valid_q;
    assign out_phys     = res.phys;
    assign out_offset   = res.offset;
    assign out_seg      = res.seg;
    assign out_is_reg   = res.is_reg;
    assign out_reg_idx  = res.reg_idx;
    assign out_mid      = res.mid;
    assign out_disp_len = res.disp_len;

    // R2: direct form takes its offset straight from the two trailing bytes
    a_r2_direct_offset: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(modrm[7:6] == 2'd0 && modrm[2:0] == 3'd6))
        |-> (out_offset == {$past(disp_hi), $past(disp_lo)} && out_disp_len == 2'd2));

    // R4: byte count never exceeds two
    a_r4_len_range: assert property (@(posedge clk) disable iff (rst)
        out_disp_len <= 2'd2);

    // R6: BP-relative pairs default to the stack segment
    a_r6_stack_default: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_is_reg && !$past(ovr_en) && $past(modrm[2:1] == 2'b01))
        |-> (out_seg == 2'd2));

    // R7: prefix wins for memory operands
    a_r7_override: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_is_reg && $past(ovr_en)) |-> (out_seg == $past(ovr_sel)));

    // R9: register operands carry no address and no displacement
    a_r9_reg_quiet: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_is_reg) |-> (out_disp_len == 2'd0 && out_phys == '0 && out_offset == '0));

    // R10: outputs hold when nothing was captured
    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        !$past(in_valid) |-> ($stable(out_phys) && $stable(out_offset) && !out_valid));

endmodule

// File: tb/sim_ea_gen.sv
`timescale 1ns/1ps
module sim_ea_gen;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [7:0]  modrm = '0, disp_lo = '0, disp_hi = '0;
    logic [15:0] reg_bx = 16'h1234, reg_bp = 16'h2000, reg_si = 16'h0030, reg_di = 16'h0400;
    logic [15:0] seg_es = 16'h1000, seg_cs = 16'h2000, seg_ss = 16'h3000, seg_ds = 16'h4000;
    logic        ovr_en = 1'b0;
    logic [1:0]  ovr_sel = '0;
    logic        out_valid, out_is_reg;
    logic [19:0] out_phys;
    logic [15:0] out_offset;
    logic [1:0]  out_seg, out_disp_len;
    logic [2:0]  out_reg_idx, out_mid;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    ea_gen u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .modrm(modrm),
        .disp_lo(disp_lo), .disp_hi(disp_hi),
        .reg_bx(reg_bx), .reg_bp(reg_bp), .reg_si(reg_si), .reg_di(reg_di),
        .seg_es(seg_es), .seg_cs(seg_cs), .seg_ss(seg_ss), .seg_ds(seg_ds),
        .ovr_en(ovr_en), .ovr_sel(ovr_sel),
        .out_valid(out_valid), .out_phys(out_phys), .out_offset(out_offset),
        .out_seg(out_seg), .out_is_reg(out_is_reg), .out_reg_idx(out_reg_idx),
        .out_mid(out_mid), .out_disp_len(out_disp_len)
    );

    task automatic check(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] seg_value(input logic [1:0] s);
        case (s)
            2'd0: return seg_es;
            2'd1: return seg_cs;
            2'd2: return seg_ss;
            default: return seg_ds;
        endcase
    endfunction

    // Drive one valid request, then sample its result one clock later.
    task automatic run_one(input string req, input logic [7:0] m, input logic [7:0] lo,
                           input logic [7:0] hi, input logic oe, input logic [1:0] os);
        int md, rm, base, disp, len, off, sg, ph;
        md = int'(m[7:6]); rm = int'(m[2:0]);
        case (rm)
            0: base = reg_bx + reg_si;  1: base = reg_bx + reg_di;
            2: base = reg_bp + reg_si;  3: base = reg_bp + reg_di;
            4: base = reg_si;           5: base = reg_di;
            6: base = reg_bp;           default: base = reg_bx;
        endcase
        disp = 0; len = 0;
        if (md == 0 && rm == 6) begin base = 0; disp = {hi, lo}; len = 2; end
        else if (md == 1) begin disp = lo[7] ? int'(lo) - 256 : int'(lo); len = 1; end
        else if (md == 2) begin disp = {hi, lo}; len = 2; end
        off = (base + disp) & 16'hFFFF;
        sg = (rm == 2 || rm == 3 || (rm == 6 && md != 0)) ? 2 : 3;
        if (oe) sg = int'(os);
        ph = ((int'(seg_value(2'(sg))) << 4) + off) & 20'hFFFFF;
        @(negedge clk);
        modrm = m; disp_lo = lo; disp_hi = hi; ovr_en = oe; ovr_sel = os; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check(req, "valid", longint'(out_valid), 1);
        check(req, "mid", longint'(out_mid), longint'(m[5:3]));
        if (md == 3) begin
            check(req, "is_reg", longint'(out_is_reg), 1);
            check(req, "reg_idx", longint'(out_reg_idx), rm);
            check(req, "phys", longint'(out_phys), 0);
            check(req, "len", longint'(out_disp_len), 0);
        end else begin
            check(req, "is_reg", longint'(out_is_reg), 0);
            check(req, "offset", longint'(out_offset), off);
            check(req, "seg", longint'(out_seg), sg);
            check(req, "phys", longint'(out_phys), ph);
            check(req, "len", longint'(out_disp_len), len);
        end
    endtask

    task automatic t_reset_r11();
        check("R11", "valid", longint'(out_valid), 0);
        check("R11", "phys", longint'(out_phys), 0);
        check("R11", "offset", longint'(out_offset), 0);
        check("R11", "len", longint'(out_disp_len), 0);
    endtask

    task automatic t_bases_r1();
        for (int r = 0; r < 8; r++)
            if (r != 6) run_one("R1", {2'b00, 3'd5, 3'(r)}, 8'hAA, 8'hBB, 1'b0, 2'd0);
        for (int r = 0; r < 8; r++)
            run_one("R6", {2'b10, 3'd0, 3'(r)}, 8'h10, 8'h00, 1'b0, 2'd0);
    endtask

    task automatic t_direct_r2();
        run_one("R2", 8'b00_011_110, 8'h34, 8'h12, 1'b0, 2'd0);
        check("R2", "exact offset", longint'(out_offset), 16'h1234);
    endtask

    task automatic t_disp8_r3();
        run_one("R3", 8'b01_000_111, 8'h05, 8'hFF, 1'b0, 2'd0);
        run_one("R3", 8'b01_000_110, 8'h80, 8'h00, 1'b0, 2'd0);
        check("R3", "neg offset", longint'(out_offset), 16'h1F80);
    endtask

    task automatic t_disp16_r4();
        run_one("R4", 8'b10_000_100, 8'h01, 8'h80, 1'b0, 2'd0);
        check("R4", "le offset", longint'(out_offset), 16'h8031);
        run_one("R4", 8'b00_000_101, 8'hFF, 8'hFF, 1'b0, 2'd0);
    endtask

    task automatic t_wrap_r5_r8();
        reg_bx = 16'hFFFF; reg_si = 16'h0002;
        run_one("R5", 8'b00_000_000, 8'h00, 8'h00, 1'b0, 2'd0);
        check("R5", "wrapped", longint'(out_offset), 16'h0001);
        reg_bx = 16'h0010;
        run_one("R5", 8'b01_000_111, 8'h80, 8'h00, 1'b0, 2'd0);
        check("R5", "neg wrap", longint'(out_offset), 16'hFF90);
        seg_ds = 16'hFFFF; reg_di = 16'h0020;
        run_one("R8", 8'b00_000_101, 8'h00, 8'h00, 1'b0, 2'd0);
        check("R8", "phys wrap", longint'(out_phys), 20'h00010);
        seg_ds = 16'h4000; reg_bx = 16'h1234; reg_si = 16'h0030; reg_di = 16'h0400;
    endtask

    task automatic t_override_r7();
        for (int s = 0; s < 4; s++) begin
            run_one("R7", 8'b01_000_010, 8'h01, 8'h00, 1'b1, 2'(s));
            run_one("R7", 8'b00_000_111, 8'h00, 8'h00, 1'b1, 2'(s));
        end
    endtask

    task automatic t_reg_r9();
        for (int r = 0; r < 8; r++)
            run_one("R9", {2'b11, 3'(7 - r), 3'(r)}, 8'h55, 8'h66, 1'b0, 2'd0);
    endtask

    task automatic t_hold_r10();
        logic [19:0] p;
        logic [15:0] o;
        run_one("R10", 8'b10_001_001, 8'h22, 8'h11, 1'b0, 2'd0);
        p = out_phys; o = out_offset;
        @(negedge clk);
        modrm = 8'b00_000_000; disp_lo = 8'h99;
        @(negedge clk);
        check("R10", "valid low", longint'(out_valid), 0);
        check("R10", "phys held", longint'(out_phys), longint'(p));
        check("R10", "offset held", longint'(out_offset), longint'(o));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset_r11();
        t_bases_r1();
        t_direct_r2();
        t_disp8_r3();
        t_disp16_r4();
        t_wrap_r5_r8();
        t_override_r7();
        t_reg_r9();
        t_hold_r10();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule